// File: doc/BRIEF.md
# Banked Interrupt Controller with Trigger Configuration

This block gathers raw interrupt lines into banks of 32 sources and presents one request line per bank, together with the position of the lowest active source in that bank. Each source can be set to one of four trigger modes: level-high, level-low, rising-edge or falling-edge. Each bank has six word registers on a simple read/write bus. They hold pending status, enable, a software set strobe, an acknowledge strobe, polarity and trigger kind.

A fixed-priority stage sits after the banks. It picks the lowest-numbered bank that has a request and reports the global source number, which is bank times 32 plus the bit position. A handler reads that number, services the source and, for an edge source, writes a one to the matching bit of the acknowledge register.

Raw inputs are asynchronous. They pass through a two-stage synchronizer before edge detection and level qualification.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every bank has enable 0, polarity 0xFFFFFFFF and trigger kind 0, except the trigger-kind word of bank 0, which resets to 0x0000E000 (bits 13..15 edge). No request line is high.
- R2: Bank b occupies byte addresses 24*b to 24*b+23. The word offsets are: status 0x00, enable 0x04, set 0x08, acknowledge 0x0C, polarity 0x10, trigger kind 0x14. Read data appears on the cycle after the read strobe.
- R3: A source whose trigger-kind bit is 0 is level triggered: active when the synchronized input equals its polarity bit (1 = high, 0 = low). Its status bit follows that condition, and writing a 1 to its acknowledge bit has no lasting effect.
- R4: A source whose trigger-kind bit is 1 latches a pending bit on a rising edge (polarity 1) or a falling edge (polarity 0). The bit stays set after the input returns and is cleared only by writing a 1 to its acknowledge bit.
- R5: Writing a 1 to a set-register bit forces that pending bit high, which gives a software interrupt. Set and acknowledge read back as 0. Writes to the status offset are ignored.
- R6: A bank's request line is high when (status AND enable) is nonzero. Its reported source index is the lowest set bit of that masked value.
- R7: The selector serves the lowest-numbered requesting bank. It outputs valid and the global number bank*32 + index.
- R8: Status reads show pending bits whether or not they are enabled. An input change shows in status 3 clock edges after it is applied, on the bank line 4 edges after, and on the selector 5 edges after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 160 | Raw sources, bank-major (bit b*32+i) |
| bank_irq | output | 5 | Per-bank request lines |
| bank_src_id | output | 25 | Per-bank lowest active index, 5 bits each |
| irq_valid | output | 1 | Any bank requesting |
| irq_num | output | 8 | Global number of the selected source |

## Verification
An input change counts three edges to the status bit (two synchronizer flops, then the pending flop). One more edge reaches the bank line and a fifth reaches the selector. The latency test drives an input on a falling clock edge and samples on the following falling edges. It checks that the bank line is still low after three edges and high after four, and that the selector is low after four and high after five. Register effects are checked one edge after the write. Read data is checked one edge after the strobe. The table-driven tests wait at least six cycles before they sample, so every result has settled by then.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BANK_STRIDE = 24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_ENABLE, SEL_SET, SEL_ACK, SEL_POL, SEL_KIND
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
    case (ofs)
      8'h00:   return SEL_STATUS;
      8'h04:   return SEL_ENABLE;
      8'h08:   return SEL_SET;
      8'h0C:   return SEL_ACK;
      8'h10:   return SEL_POL;
      8'h14:   return SEL_KIND;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int              NSRC       = 32,
  parameter int              ID_W       = $clog2(NSRC),
  parameter logic [NSRC-1:0] KIND_RESET = '0,
  parameter logic [NSRC-1:0] POL_RESET  = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] sync_i,
  input  logic            wr_i,
  input  reg_sel_e        sel_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic [ID_W-1:0] id_o
);
  logic [NSRC-1:0] en_q, pol_q, kind_q, pend_q, prev_q;
  logic [NSRC-1:0] set_vec, ack_vec, qual, rise, fall, hit_edge, pend_nxt, masked;
  logic [ID_W-1:0] low_idx;
  logic            irq_q;
  logic [ID_W-1:0] id_q;

  assign set_vec = (wr_i && sel_i == SEL_SET) ? wdata_i : '0;
  assign ack_vec = (wr_i && sel_i == SEL_ACK) ? wdata_i : '0;

  // Trigger qualification
  assign qual     = ~(sync_i ^ pol_q);
  assign rise     = sync_i & ~prev_q;
  assign fall     = ~sync_i & prev_q;
  assign hit_edge = (pol_q & rise) | (~pol_q & fall);
  assign pend_nxt = set_vec
                  | (kind_q & ((pend_q & ~ack_vec) | hit_edge))
                  | (~kind_q & qual);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= POL_RESET;
      kind_q <= KIND_RESET;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_nxt;
      if (wr_i && sel_i == SEL_ENABLE) en_q   <= wdata_i;
      if (wr_i && sel_i == SEL_POL)    pol_q  <= wdata_i;
      if (wr_i && sel_i == SEL_KIND)   kind_q <= wdata_i;
    end
  end

  assign masked = pend_q & en_q;

  always_comb begin
    low_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (masked[i]) low_idx = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= |masked;
      id_q  <= low_idx;
    end
  end

  assign irq_o = irq_q;
  assign id_o  = id_q;

  always_comb begin
    case (sel_i)
      SEL_STATUS: rdata_o = pend_q;
      SEL_ENABLE: rdata_o = en_q;
      SEL_POL:    rdata_o = pol_q;
      SEL_KIND:   rdata_o = kind_q;
      default:    rdata_o = '0;
    endcase
  end

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q ^ $past(qual)) & $past(~kind_q & ~set_vec)) == '0); // R3
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend_q | ~$past(pend_q & kind_q & ~ack_vec)) == '1); // R4
  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == $past(|masked)); // R6
  AST_ID_LOWEST: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !irq_o || (($past(masked) >> id_o) & NSRC'(1)) == NSRC'(1)); // R6
  AST_ID_NONE_BELOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(masked) & ((NSRC'(1) << id_o) - NSRC'(1))) == '0); // R6
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NBANK  = 5,
  parameter int ID_W   = 5,
  parameter int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int NUM_W  = BANK_W + ID_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBANK-1:0]      req_i,
  input  logic [NBANK*ID_W-1:0] id_i,
  output logic                  valid_o,
  output logic [NUM_W-1:0]      num_o
);
  logic             any;
  logic [NUM_W-1:0] pick;
  logic             valid_q;
  logic [NUM_W-1:0] num_q;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (req_i[b]) begin
        any  = 1'b1;
        pick = {BANK_W'(b), id_i[b*ID_W +: ID_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else begin
      valid_q <= any;
      num_q   <= pick;
    end
  end

  assign valid_o = valid_q;
  assign num_o   = num_q;

  AST_BANK0_FIRST: assert property (@(posedge clk) disable iff (rst)
    $past(req_i[0]) |-> valid_o && num_o[NUM_W-1 -: BANK_W] == '0); // R7
  AST_VALID_ANY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> valid_o == $past(|req_i)); // R7
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int              NUM_BANKS    = 5,
  parameter int              SRC_PER_BANK = 32,
  parameter int              ADDR_W       = 8,
  parameter logic [SRC_PER_BANK-1:0] BANK0_KIND_INIT = SRC_PER_BANK'(32'h0000_E000),
  parameter int              ID_W         = $clog2(SRC_PER_BANK),
  parameter int              BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int              NUM_W        = BANK_W + ID_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [SRC_PER_BANK-1:0]        bus_wdata,
  output logic [SRC_PER_BANK-1:0]        bus_rdata,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_in,
  output logic [NUM_BANKS-1:0]           bank_irq,
  output logic [NUM_BANKS*ID_W-1:0]      bank_src_id,
  output logic                           irq_valid,
  output logic [NUM_W-1:0]               irq_num
);
  localparam int TOTAL = NUM_BANKS * SRC_PER_BANK;

  logic [TOTAL-1:0]              src_sync;
  logic [NUM_BANKS-1:0]          bank_hit;
  logic [NUM_BANKS-1:0]          strobe_hit;
  logic [SRC_PER_BANK-1:0]       bank_rd [NUM_BANKS];
  logic [SRC_PER_BANK-1:0]       rd_mux;
  logic [SRC_PER_BANK-1:0]       rdata_q;
  logic                          strobe_sel;

  irq_sync #(.WIDTH(TOTAL)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (src_in),
    .sync_o  (src_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] ofs;
    reg_sel_e          sel;

    assign bank_hit[b] = (bus_addr >= ADDR_W'(b * BANK_STRIDE)) &&
                         (bus_addr <  ADDR_W'((b + 1) * BANK_STRIDE));
    assign ofs         = bus_addr - ADDR_W'(b * BANK_STRIDE);
    assign sel         = bank_hit[b] ? decode_offset(8'(ofs)) : SEL_NONE;
    assign strobe_hit[b] = (sel == SEL_SET) || (sel == SEL_ACK);

    irq_bank #(
      .NSRC       (SRC_PER_BANK),
      .ID_W       (ID_W),
      .KIND_RESET ((b == 0) ? BANK0_KIND_INIT : '0),
      .POL_RESET  ('1)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .sync_i  (src_sync[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .wr_i    (bus_wr && bank_hit[b]),
      .sel_i   (sel),
      .wdata_i (bus_wdata),
      .rdata_o (bank_rd[b]),
      .irq_o   (bank_irq[b]),
      .id_o    (bank_src_id[b*ID_W +: ID_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd_mux = rd_mux | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign strobe_sel = |strobe_hit;

  irq_prio_sel #(
    .NBANK  (NUM_BANKS),
    .ID_W   (ID_W),
    .BANK_W (BANK_W),
    .NUM_W  (NUM_W)
  ) u_sel (
    .clk     (clk),
    .rst     (rst),
    .req_i   (bank_irq),
    .id_i    (bank_src_id),
    .valid_o (irq_valid),
    .num_o   (irq_num)
  );

  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && strobe_sel) |=> bus_rdata == '0); // R5
  AST_ONE_BANK_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_hit)); // R2
endmodule

// File: tb/test_banked_irq_ctrl.sv
`timescale 1ns/1ps
module test_banked_irq_ctrl;
  localparam int NB = 5;
  localparam int NS = 32;
  localparam int O_STAT = 'h00, O_EN = 'h04, O_SET = 'h08, O_ACK = 'h0C, O_POL = 'h10, O_KIND = 'h14;

  logic            clk = 0;
  logic            rst = 1;
  logic            bus_wr = 0, bus_rd = 0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NB*NS-1:0] src = '0;
  logic [NB-1:0]   bank_irq;
  logic [NB*5-1:0] bank_src_id;
  logic            irq_valid;
  logic [7:0]      irq_num;
  int              errors = 0, checks = 0;
  logic [31:0]     rv;

  always #2.5 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src),
    .bank_irq(bank_irq), .bank_src_id(bank_src_id),
    .irq_valid(irq_valid), .irq_num(irq_num)
  );

  // {bank[2:0], bit[4:0], polarity, edge}
  localparam logic [9:0] VEC [8] = '{
    {3'd0, 5'd3,  1'b1, 1'b0},
    {3'd1, 5'd17, 1'b0, 1'b0},
    {3'd2, 5'd31, 1'b1, 1'b1},
    {3'd3, 5'd0,  1'b0, 1'b1},
    {3'd4, 5'd12, 1'b1, 1'b1},
    {3'd0, 5'd14, 1'b1, 1'b1},
    {3'd4, 5'd25, 1'b0, 1'b0},
    {3'd2, 5'd8,  1'b0, 1'b1}
  };

  function automatic logic [7:0] ra(int b, int ofs);
    return 8'(b * 24 + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(4);
    rst = 0;
    cyc(2);
    // R1 reset state
    chk("R1 irq_valid", 32'(irq_valid), 0);
    chk("R1 bank_irq", 32'(bank_irq), 0);
    rd(ra(0, O_KIND), rv); chk("R1 bank0 kind", rv, 32'h0000E000);
    rd(ra(1, O_KIND), rv); chk("R1 bank1 kind", rv, 0);
    rd(ra(2, O_POL), rv);  chk("R1 R2 bank2 polarity", rv, 32'hFFFFFFFF);
    rd(ra(3, O_EN), rv);   chk("R1 bank3 enable", rv, 0);

    // table walk: R3 R4 R6 R7
    for (int k = 0; k < 8; k++) begin
      int b, bt; logic pol, edg;
      b = int'(VEC[k][9:7]); bt = int'(VEC[k][6:2]); pol = VEC[k][1]; edg = VEC[k][0];
      wr(ra(b, O_POL), pol ? 32'hFFFFFFFF : ~(32'd1 << bt));
      wr(ra(b, O_KIND), edg ? (32'd1 << bt) : 32'd0);
      src[b*NS + bt] = ~pol;
      cyc(6);
      wr(ra(b, O_ACK), 32'hFFFFFFFF);
      cyc(4);
      wr(ra(b, O_EN), 32'd1 << bt);
      cyc(3);
      chk("R6 idle no request", 32'(irq_valid), 0);
      src[b*NS + bt] = pol;
      cyc(6);
      chk(edg ? "R4 edge bank line" : "R3 level bank line", 32'(bank_irq[b]), 1);
      chk("R7 global number", 32'(irq_num), 32'(b*NS + bt));
      src[b*NS + bt] = ~pol;
      cyc(6);
      chk(edg ? "R4 edge latched after return" : "R3 level follows input", 32'(irq_valid), 32'(edg));
      wr(ra(b, O_ACK), 32'd1 << bt);
      cyc(4);
      chk("R4 acknowledge clears", 32'(irq_valid), 0);
      wr(ra(b, O_EN), 0);
      src[b*NS + bt] = 0;
      cyc(6);
      wr(ra(b, O_POL), 32'hFFFFFFFF);
      wr(ra(b, O_KIND), (b == 0) ? 32'h0000E000 : 32'd0);
      wr(ra(b, O_ACK), 32'hFFFFFFFF);
      cyc(4);
    end

    // R6 lowest set bit within a bank
    wr(ra(4, O_EN), (32'd1 << 9) | (32'd1 << 30));
    src[4*NS + 9] = 1; src[4*NS + 30] = 1;
    cyc(6);
    chk("R6 lowest index", 32'(bank_src_id[4*5 +: 5]), 9);
    chk("R6 R7 number", 32'(irq_num), 137);
    src[4*NS + 9] = 0;
    cyc(6);
    chk("R6 next index", 32'(irq_num), 158);
    src[4*NS + 30] = 0;
    wr(ra(4, O_EN), 0);
    cyc(6);

    // R7 bank priority
    wr(ra(3, O_EN), 32'd1 << 2);
    wr(ra(1, O_EN), 32'd1 << 20);
    src[3*NS + 2] = 1; src[1*NS + 20] = 1;
    cyc(6);
    chk("R7 lower bank wins", 32'(irq_num), 52);
    src[1*NS + 20] = 0;
    cyc(6);
    chk("R7 fallback bank", 32'(irq_num), 98);
    src[3*NS + 2] = 0;
    wr(ra(3, O_EN), 0); wr(ra(1, O_EN), 0);
    cyc(6);

    // R5 software set on edge source bank0 bit14
    wr(ra(0, O_EN), 32'd1 << 14);
    wr(ra(0, O_SET), 32'd1 << 14);
    cyc(3);
    chk("R5 set raises request", 32'(irq_valid), 1);
    chk("R5 set number", 32'(irq_num), 14);
    rd(ra(0, O_SET), rv); chk("R5 set reads zero", rv, 0);
    rd(ra(0, O_ACK), rv); chk("R5 ack reads zero", rv, 0);
    wr(ra(0, O_STAT), 32'd0);
    rd(ra(0, O_STAT), rv); chk("R5 status write ignored", rv & (32'd1 << 14), 32'd1 << 14);
    wr(ra(0, O_ACK), 32'd1 << 14);
    cyc(3);
    chk("R5 ack after set", 32'(irq_valid), 0);
    wr(ra(0, O_EN), 0);

    // R8 status regardless of enable, R3 ack no effect on level
    src[2*NS + 5] = 1;
    cyc(6);
    chk("R8 disabled gives no request", 32'(irq_valid), 0);
    rd(ra(2, O_STAT), rv); chk("R8 status unmasked", rv, 32'd1 << 5);
    wr(ra(2, O_ACK), 32'd1 << 5);
    cyc(3);
    rd(ra(2, O_STAT), rv); chk("R3 ack no lasting effect", rv, 32'd1 << 5);
    src[2*NS + 5] = 0;
    cyc(6);

    // R8 latency
    wr(ra(1, O_EN), 32'd1 << 1);
    cyc(2);
    @(negedge clk);
    src[1*NS + 1] = 1;
    cyc(3);
    chk("R8 bank line low at edge 3", 32'(bank_irq[1]), 0);
    cyc(1);
    chk("R8 bank line high at edge 4", 32'(bank_irq[1]), 1);
    chk("R8 selector low at edge 4", 32'(irq_valid), 0);
    cyc(1);
    chk("R8 selector high at edge 5", 32'(irq_valid), 1);
    chk("R8 selector number", 32'(irq_num), 33);

    finish_run();
  end
endmodule